// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt lines (96 by default, up to 128) into one interrupt request for a processor. The lines are grouped into 32-bit banks. Each line can be masked or unmasked without a read-modify-write, using write-one alias registers. Each line carries a 6-bit priority. A programmable threshold filters out lines whose priority is too weak. The controller picks the strongest eligible line and latches its number. The request output stays high until software acknowledges the latched number. Only after that acknowledge does the controller pick again.

Software uses it like this. On an interrupt it reads the active-number register to find out which line fired, and services that line. It then writes the acknowledge bit so the next line can be presented. Per-bank pending registers show which lines are both raised and unmasked. A soft-reset bit returns every register to its reset value, and a status flag reports when that reset has finished. The configuration, protection and idle fields are stored so that software can save and restore them. They have no effect on the interrupt logic.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is low and every mask bit is 1, so each bank's mask register reads 0xFFFFFFFF. The status register (0x14) reads 1, the threshold (0x68) reads 0xFF, and the revision register (0x00) reads 0x40: major version 4 in bits [7:4], minor version 0 in bits [3:0].
- R2: Mask writes use alias registers for bank n:
  - 0x84+0x20*n reads and writes the mask directly.
  - Writing ones to 0x88+0x20*n clears those mask bits, which enables the lines.
  - Writing ones to 0x8C+0x20*n sets those mask bits.
  - Zero bits written to either alias leave the mask unchanged.
- R3: The read-only register at 0x98+0x20*n returns the bank's input lines ANDed with the inverse of its mask.
- R4: Arbitration and reporting:
  - The line with the lowest priority value is selected. The priority value is held in bits [7:2] of the line's level register at 0x100+4*i.
  - On equal priority, the lower line number wins.
  - The selected number is reported in bits [6:0] of register 0x40.
- R5: A line is eligible only if it is raised, unmasked, and its priority value is strictly below the threshold (0x68, bits [7:0]). A threshold of 0xFF removes this filter.
- R6: When no number is latched and an eligible line appears, `irq_o` rises on the next clock edge with that line's number latched.
- R7: While a number is latched and no acknowledge is written, the active number and `irq_o` do not change, even if a stronger line arrives.
- R8: Acknowledge timing:
  - Writing 1 to bit 0 of 0x48 drops `irq_o` on the next clock edge.
  - A new arbitration result is latched on the edge after that.
- R9: Soft reset (bit 1 of 0x10):
  - Writing 1 to this bit starts a soft reset. The bit reads 1 for exactly one cycle and then clears itself.
  - When it clears, all masks are set, all level registers are zero, the threshold is 0xFF, the other stored fields are zero, and `irq_o` is low.
  - Status bit 0 reads 0 from the write until one cycle after the reset bit clears, and then reads 1.
- R10: The following fields read back what was written: config bit 0 (auto-idle), protection bit 0 (0x4C), idle bits [1:0] (0x50), threshold bits [7:0], and level bits [7:2]. Other level bits read 0. Auto-idle has no effect on arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 12 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted mask or level entry shows up in two places on the very next read: in the pending register, and in the next number reported in the active register. Random mask, priority and threshold mixes are therefore compared against a bench model after every arbitration. A latch that fails to hold, or releases early, shows up within one cycle as a changed active number or as `irq_o` dropping without an acknowledge. A soft-reset sequencer that is off by a cycle shows up in the status bit, which is sampled in each of the three cycles after the write.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;

    localparam int BANK_W = 32;

    localparam logic [11:0] A_REV      = 12'h000;
    localparam logic [11:0] A_CFG      = 12'h010;
    localparam logic [11:0] A_STAT     = 12'h014;
    localparam logic [11:0] A_ACT      = 12'h040;
    localparam logic [11:0] A_CTRL     = 12'h048;
    localparam logic [11:0] A_PROT     = 12'h04C;
    localparam logic [11:0] A_IDLE     = 12'h050;
    localparam logic [11:0] A_THR      = 12'h068;
    localparam logic [11:0] A_LVL_BASE = 12'h100;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_MASK,
        BK_CLR,
        BK_SET,
        BK_PEND
    } bank_reg_e;

    typedef struct packed {
        logic [7:0] thr;
        logic [1:0] idle;
        logic       prot;
        logic       autoidle;
    } misc_regs_t;

    localparam misc_regs_t MISC_RST = '{thr: 8'hFF, idle: 2'b00, prot: 1'b0, autoidle: 1'b0};

    // Offset of a bank register inside its 32-byte window.
    function automatic bank_reg_e bank_kind(input logic [4:0] off);
        case (off)
            5'h04:   return BK_MASK;
            5'h08:   return BK_CLR;
            5'h0C:   return BK_SET;
            5'h18:   return BK_PEND;
            default: return BK_NONE;
        endcase
    endfunction

    function automatic logic prio_passes(input logic [5:0] prio, input logic [7:0] thr);
        return (thr == 8'hFF) || ({2'b00, prio} < thr);
    endfunction

endpackage

// File: rtl/vic_regfile.sv
`timescale 1ns/1ps
module vic_regfile
    import vic_pkg::*;
#(
    parameter int         NUM_SRC   = 96,
    parameter logic [3:0] REV_MAJOR = 4'd4,
    parameter logic [3:0] REV_MINOR = 4'd0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_sel,
    input  logic                     bus_we,
    input  logic [11:0]              bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_SRC-1:0]       src_i,
    input  logic [6:0]               act_num,
    output logic [NUM_SRC-1:0]       mask_o,
    output logic [NUM_SRC-1:0][5:0]  prio_o,
    output logic [7:0]               thr_o,
    output logic                     ack_o,
    output logic                     clr_o
);
    localparam int NB  = NUM_SRC / BANK_W;
    localparam int BIW = (NB > 1) ? $clog2(NB) : 1;
    localparam int IW  = $clog2(NUM_SRC);

    logic [NB-1:0][BANK_W-1:0] mask_q;
    logic [NB-1:0][BANK_W-1:0] src_b;
    logic [NUM_SRC-1:0][5:0]   prio_q;
    misc_regs_t                misc_q;
    logic                      srst_q, done_arm_q, done_q;

    logic            wr;
    logic            in_bank, in_lvl;
    logic [BIW-1:0]  bsel;
    bank_reg_e       bkind;
    logic [11:0]     lvl_off;
    logic [IW-1:0]   lvl_idx;
    logic            unused_lvl;

    assign src_b      = src_i;
    assign wr         = bus_sel && bus_we;
    assign bsel       = bus_addr[5 +: BIW];
    assign bkind      = bank_kind(bus_addr[4:0]);
    assign in_bank    = (bus_addr[11:7] == 5'b00001) && (int'(bus_addr[6:5]) < NB);
    assign lvl_off    = bus_addr - A_LVL_BASE;
    assign in_lvl     = (bus_addr >= A_LVL_BASE) && (int'(lvl_off[11:2]) < NUM_SRC);
    assign lvl_idx    = lvl_off[IW+1:2];
    assign unused_lvl = ^lvl_off[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '1;
            prio_q     <= '0;
            misc_q     <= MISC_RST;
            srst_q     <= 1'b0;
            done_arm_q <= 1'b0;
            done_q     <= 1'b1;
        end else begin
            srst_q     <= 1'b0;
            done_arm_q <= 1'b0;
            if (done_arm_q) done_q <= 1'b1;
            if (srst_q) begin
                mask_q     <= '1;
                prio_q     <= '0;
                misc_q     <= MISC_RST;
                done_arm_q <= 1'b1;
            end else if (wr) begin
                case (bus_addr)
                    A_CFG: begin
                        misc_q.autoidle <= bus_wdata[0];
                        if (bus_wdata[1]) begin
                            srst_q <= 1'b1;
                            done_q <= 1'b0;
                        end
                    end
                    A_PROT: misc_q.prot <= bus_wdata[0];
                    A_IDLE: misc_q.idle <= bus_wdata[1:0];
                    A_THR:  misc_q.thr  <= bus_wdata[7:0];
                    default: begin
                        if (in_bank) begin
                            case (bkind)
                                BK_MASK: mask_q[bsel] <= bus_wdata;
                                BK_CLR:  mask_q[bsel] <= mask_q[bsel] & ~bus_wdata;
                                BK_SET:  mask_q[bsel] <= mask_q[bsel] | bus_wdata;
                                default: ;
                            endcase
                        end else if (in_lvl) begin
                            prio_q[lvl_idx] <= bus_wdata[7:2];
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_REV:  bus_rdata = {24'b0, REV_MAJOR, REV_MINOR};
            A_CFG:  bus_rdata = {30'b0, srst_q, misc_q.autoidle};
            A_STAT: bus_rdata = {31'b0, done_q};
            A_ACT:  bus_rdata = {25'b0, act_num};
            A_PROT: bus_rdata = {31'b0, misc_q.prot};
            A_IDLE: bus_rdata = {30'b0, misc_q.idle};
            A_THR:  bus_rdata = {24'b0, misc_q.thr};
            default: begin
                if (in_bank) begin
                    if (bkind == BK_MASK)      bus_rdata = mask_q[bsel];
                    else if (bkind == BK_PEND) bus_rdata = src_b[bsel] & ~mask_q[bsel];
                end else if (in_lvl) begin
                    bus_rdata = {24'b0, prio_q[lvl_idx], 2'b00};
                end
            end
        endcase
    end

    assign mask_o = mask_q;
    assign prio_o = prio_q;
    assign thr_o  = misc_q.thr;
    assign ack_o  = wr && (bus_addr == A_CTRL) && bus_wdata[0];
    assign clr_o  = srst_q;

endmodule

// File: rtl/vic_arbiter.sv
`timescale 1ns/1ps
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic [NUM_SRC-1:0]      src_i,
    input  logic [NUM_SRC-1:0]      mask_i,
    input  logic [NUM_SRC-1:0][5:0] prio_i,
    input  logic [7:0]              thr_i,
    output logic                    cand_v,
    output logic [6:0]              cand_id
);
    localparam int IW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] elig;
    logic [5:0]         best_p;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = src_i[g] && !mask_i[g] && prio_passes(prio_i[g], thr_i);
    end

    // Strict less-than keeps the lower index on equal priority.
    always_comb begin
        cand_v  = 1'b0;
        cand_id = '0;
        best_p  = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i[IW-1:0]] && (!cand_v || (prio_i[i[IW-1:0]] < best_p))) begin
                cand_v  = 1'b1;
                cand_id = 7'(i);
                best_p  = prio_i[i[IW-1:0]];
            end
        end
    end

endmodule

// File: rtl/vic_active.sv
`timescale 1ns/1ps
module vic_active (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ack,
    input  logic       cand_v,
    input  logic [6:0] cand_id,
    output logic [6:0] act_num,
    output logic       act_valid
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            act_valid <= 1'b0;
            act_num   <= '0;
        end else if (act_valid) begin
            if (ack) act_valid <= 1'b0;
        end else if (cand_v) begin
            act_valid <= 1'b1;
            act_num   <= cand_id;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int         NUM_SRC   = 96,
    parameter logic [3:0] REV_MAJOR = 4'd4,
    parameter logic [3:0] REV_MINOR = 4'd0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0]      mask;
    logic [NUM_SRC-1:0][5:0] prio;
    logic [7:0]              thr;
    logic                    ack, soft_clr;
    logic                    cand_v, act_valid;
    logic [6:0]              cand_id, act_num;

    vic_regfile #(
        .NUM_SRC(NUM_SRC), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_i(src_i), .act_num(act_num),
        .mask_o(mask), .prio_o(prio), .thr_o(thr),
        .ack_o(ack), .clr_o(soft_clr)
    );

    vic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .src_i(src_i), .mask_i(mask), .prio_i(prio), .thr_i(thr),
        .cand_v(cand_v), .cand_id(cand_id)
    );

    vic_active u_act (
        .clk(clk), .rst(rst), .clr(soft_clr), .ack(ack),
        .cand_v(cand_v), .cand_id(cand_id),
        .act_num(act_num), .act_valid(act_valid)
    );

    assign irq_o = act_valid;

endmodule

// File: rtl/vic_checker.sv
`timescale 1ns/1ps
module vic_checker #(
    parameter int NUM_SRC = 96
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        irq_o,
    input logic [6:0]  act_num,
    input logic        soft_clr
);
    logic ack_w, srst_w, unused_bits;

    assign ack_w       = bus_sel && bus_we && (bus_addr == 12'h048) && bus_wdata[0];
    assign srst_w      = bus_sel && bus_we && (bus_addr == 12'h010) && bus_wdata[1];
    assign unused_bits = ^bus_wdata[31:2];

    // R7
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack_w && !soft_clr) |=> (irq_o && $stable(act_num)));

    // R8
    a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_w) |=> !irq_o);

    // R9
    a_r9_srst_starts: assert property (@(posedge clk) disable iff (rst)
        (srst_w && !soft_clr) |=> soft_clr);

    // R9
    a_r9_srst_self_clears: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (!soft_clr && !irq_o));

    // R4
    a_r4_num_in_range: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ({25'b0, act_num} < NUM_SRC));

endmodule

bind vec_irq_ctrl vic_checker #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/100ps
module vec_irq_ctrl_test;
    localparam int N = 96;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  src;
    logic          bus_sel, bus_we;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          irq_o;

    int ntests, nfail;
    bit finished;

    logic [N-1:0] m_mask;
    logic [5:0]   m_prio [N];
    logic [7:0]   m_thr;

    vec_irq_ctrl #(.NUM_SRC(N)) uut (
        .clk(clk), .rst(rst), .src_i(src), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic int exp_winner(input logic [N-1:0] s);
        int best = -1;
        int bp = 99;
        for (int i = 0; i < N; i++) begin
            if (s[i] && !m_mask[i] && (m_thr == 8'hFF || {2'b00, m_prio[i]} < m_thr)) begin
                if (best < 0 || int'(m_prio[i]) < bp) begin
                    best = i;
                    bp = int'(m_prio[i]);
                end
            end
        end
        return best;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            ntests++; nfail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, v;
        int seed, b, k, p, w;
        ntests = 0; nfail = 0; finished = 0;
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; src = '0;
        seed = $urandom(32'h00C0FFEE);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 32'd0);
        rd(12'h000, r); chk("R1 revision", r, 32'h40);
        rd(12'h084, r); chk("R1 mask bank0", r, 32'hFFFFFFFF);
        rd(12'h0C4, r); chk("R1 mask bank2", r, 32'hFFFFFFFF);
        @(negedge clk);
        rd(12'h014, r); chk("R1 status", r, 32'd1);
        rd(12'h068, r); chk("R1 threshold", r, 32'hFF);

        // R10 stored fields
        wr(12'h010, 32'h1); rd(12'h010, r); chk("R10 autoidle", r, 32'h1);
        wr(12'h04C, 32'hFFFF_FFFF); rd(12'h04C, r); chk("R10 protection", r, 32'h1);
        wr(12'h050, 32'h7); rd(12'h050, r); chk("R10 idle", r, 32'h3);
        wr(12'h068, 32'h137); rd(12'h068, r); chk("R10 threshold", r, 32'h37);
        wr(12'h11C, 32'hFF); rd(12'h11C, r); chk("R10 level", r, 32'hFC);
        wr(12'h068, 32'hFF);

        // R2 alias masking on bank 1
        wr(12'h0A8, 32'h0000_00F0); rd(12'h0A4, r); chk("R2 clear alias", r, 32'hFFFF_FF0F);
        wr(12'h0AC, 32'h0000_0030); rd(12'h0A4, r); chk("R2 set alias", r, 32'hFFFF_FF3F);
        wr(12'h0AC, 32'h0); rd(12'h0A4, r); chk("R2 zero no effect", r, 32'hFFFF_FF3F);
        wr(12'h0A8, 32'h0); rd(12'h0A4, r); chk("R2 zero clr no effect", r, 32'hFFFF_FF3F);

        // R3 pending, R6 timing, R4 tie-break on lines 38/39
        src = '0; src[39:36] = 4'hF;
        rd(12'h0B8, r); chk("R3 pending bank1", r, 32'h0000_00C0);
        chk("R6 irq not yet", {31'b0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R6 irq raised", {31'b0, irq_o}, 32'd1);
        rd(12'h040, r); chk("R4 tie lower index", r & 32'h7F, 32'd38);
        src = '0;
        wr(12'h048, 32'h1); chk("R8 ack drops irq", {31'b0, irq_o}, 32'd0);
        @(negedge clk); chk("R8 nothing to present", {31'b0, irq_o}, 32'd0);

        // R7/R8/R4 hold then re-arbitrate
        wr(12'h114, 32'd10 << 2);
        wr(12'h108, 32'd1 << 2);
        wr(12'h088, 32'h24);
        src[5] = 1'b1;
        @(negedge clk);
        rd(12'h040, r); chk("R4 active line 5", r & 32'h7F, 32'd5);
        src[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(12'h040, r); chk("R7 frozen active", r & 32'h7F, 32'd5);
        chk("R7 irq held", {31'b0, irq_o}, 32'd1);
        wr(12'h048, 32'h1); chk("R8 irq low after ack", {31'b0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R8 irq re-raised", {31'b0, irq_o}, 32'd1);
        rd(12'h040, r); chk("R4 stronger line wins", r & 32'h7F, 32'd2);
        src = '0; wr(12'h048, 32'h1);

        // R5 threshold
        wr(12'h068, 32'd2);
        src[5] = 1'b1;
        @(negedge clk); chk("R5 filtered by threshold", {31'b0, irq_o}, 32'd0);
        wr(12'h068, 32'd10);
        @(negedge clk); chk("R5 equal not below", {31'b0, irq_o}, 32'd0);
        wr(12'h068, 32'd11);
        chk("R5 one cycle after thr write", {31'b0, irq_o}, 32'd0);
        @(negedge clk); chk("R5 passes", {31'b0, irq_o}, 32'd1);
        rd(12'h040, r); chk("R5 active", r & 32'h7F, 32'd5);
        wr(12'h068, 32'hFF);

        // R9 soft reset while an interrupt is latched
        wr(12'h048, 32'h1);
        @(negedge clk);
        chk("R9 pre irq", {31'b0, irq_o}, 32'd1);
        wr(12'h010, 32'h2);
        rd(12'h010, r); chk("R9 bit set", r, 32'h2);
        rd(12'h014, r); chk("R9 done low", r, 32'd0);
        @(negedge clk);
        rd(12'h010, r); chk("R9 bit self-clears", r, 32'h0);
        rd(12'h014, r); chk("R9 done still low", r, 32'd0);
        chk("R9 irq cleared", {31'b0, irq_o}, 32'd0);
        @(negedge clk);
        rd(12'h014, r); chk("R9 done high", r, 32'd1);
        rd(12'h084, r); chk("R9 masks set", r, 32'hFFFFFFFF);
        rd(12'h114, r); chk("R9 level zero", r, 32'd0);
        @(negedge clk);
        rd(12'h068, r); chk("R9 threshold", r, 32'hFF);
        rd(12'h04C, r); chk("R9 protection", r, 32'd0);
        chk("R9 irq stays low", {31'b0, irq_o}, 32'd0);
        src = '0;

        m_mask = '1; m_thr = 8'hFF;
        for (int i = 0; i < N; i++) m_prio[i] = '0;

        // Random mixes: R2 R3 R4 R5 R6
        for (int it = 0; it < 30; it++) begin
            src = '0;
            wr(12'h048, 32'h1);
            for (int j = 0; j < 3; j++) begin
                b = int'($urandom % 3);
                v = $urandom;
                wr(12'h088 + 12'(b * 32), v);
                m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~v;
                v = $urandom & $urandom;
                wr(12'h08C + 12'(b * 32), v);
                m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | v;
            end
            for (int j = 0; j < 6; j++) begin
                k = int'($urandom % N);
                p = int'($urandom % 64);
                wr(12'h100 + 12'(k * 4), 32'(p) << 2);
                m_prio[k] = 6'(p);
            end
            m_thr = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom % 64);
            wr(12'h068, {24'b0, m_thr});
            src = {$urandom, $urandom, $urandom};
            w = exp_winner(src);
            @(negedge clk);
            chk("R6 random irq", {31'b0, irq_o}, (w >= 0) ? 32'd1 : 32'd0);
            if (w >= 0) begin
                rd(12'h040, r); chk("R4 R5 random winner", r & 32'h7F, 32'(w));
            end
            b = int'($urandom % 3);
            rd(12'h098 + 12'(b * 32), r);
            chk("R3 random pending", r, src[b*32 +: 32] & ~m_mask[b*32 +: 32]);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule